// File: doc/BRIEF.md
# Tag Array Guard with Single-Error Correction and Scrub-and-Retry

This block holds the tags of a small set-associative cache. Each tag is stored as a 38-bit protected codeword: 31 tag bits, 6 Hamming check bits and one overall parity bit. Every lookup decodes the codeword of each valid way in the addressed set. When all of them are clean, the lookup answers at once with hit or miss and the way that matched.

When a stored codeword has one flipped bit, the block writes the repaired codeword back into the array. It then reads the set again and answers from the repaired contents. When a codeword has two flipped bits, the block clears that entry's valid bit instead, so the lookup becomes a miss that the refill logic outside can service. The other ways in the set are left as they were.

A fill port installs tags. It takes a bit-flip mask that is XORed into the freshly encoded codeword, which models storage upsets. Sticky flags and saturating counters report correctable and uncorrectable events separately.

Top module: `secded_tag_check`

## Requirements
- R1: Codeword layout: bit 0 is overall even parity over all 38 bits. Bits 1, 2, 4, 8, 16 and 32 are check bits. The tag bits fill the remaining positions in ascending order. A lookup accepted (req_valid_i and req_ready_o high at a rising edge) whose set holds only clean codewords raises rsp_valid_o for exactly one cycle, two rising edges after acceptance. rsp_hit_o is 1 when a valid way's tag equals req_tag_i, and rsp_way_o then gives that way.
- R2: A lookup whose tag matches no valid way in the set answers rsp_hit_o = 0.
- R3: A lookup that finds a one-bit error in any of the 38 bits of any valid way answers four rising edges after acceptance, with the correct hit or miss and the correct way. req_ready_o stays low from acceptance until the response.
- R4: After a one-bit repair, the entry holds a clean codeword. The next lookup of that set answers with the two-edge latency and adds no event.
- R5: A two-bit error in a valid way clears that way's valid bit, and the lookup answers four edges after acceptance as a miss for that tag. The other ways of the set keep their contents and still hit.
- R6: After such an invalidation, later lookups of the same tag miss with the two-edge latency and add no event.
- R7: Each lookup that repairs ways adds the number of repaired ways to ce_count_o and sets err_ce_o. Each lookup that invalidates ways adds the number of invalidated ways to ue_count_o and sets err_ue_o. The two kinds are tracked independently, and the flags stay set until reset.
- R8: Both counters saturate at 2^CNT_W-1 and never decrease.
- R9: After reset, req_ready_o = 1, rsp_valid_o = 0, both flags and both counters are 0, and every entry is invalid.
- R10: A fill writes encode(fill_tag_i) XOR fill_flip_i into the entry (fill_set_i, fill_way_i) and marks it valid at the rising edge where fill_valid_i is high.
- R11: A flip in the overall parity bit alone (bit 0) is a correctable event. It is scrubbed and retried like any other one-bit error, and the tag value is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Lookup request |
| req_ready_o | output | 1 | Block can accept a lookup |
| req_set_i | input | SET_W | Set index of the lookup |
| req_tag_i | input | 31 | Tag to compare |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_hit_o | output | 1 | Lookup hit |
| rsp_way_o | output | WAY_W | Way that hit |
| fill_valid_i | input | 1 | Install a tag |
| fill_set_i | input | SET_W | Fill set index |
| fill_way_i | input | WAY_W | Fill way index |
| fill_tag_i | input | 31 | Tag to install |
| fill_flip_i | input | 38 | Bits inverted in the stored codeword |
| err_ce_o | output | 1 | Sticky: a correctable event occurred |
| err_ue_o | output | 1 | Sticky: an uncorrectable event occurred |
| ce_count_o | output | CNT_W | Saturating count of repaired ways |
| ue_count_o | output | CNT_W | Saturating count of invalidated ways |

## Verification
The bench flips every one of the 38 bits in every set and way, including the parity-only bit 0, and expects a four-edge answer followed by a two-edge answer. A design that repaired wrongly, or never wrote the repair back, would either answer with the wrong hit or take the slow path again.

It then flips every pair of bits in one way while a clean neighbour sits in the same set. A design that mistook a double error for a single one would "repair" it into a wrong tag. A design that killed the whole set would lose the neighbour's hit.

A mixed set holds one correctable and one uncorrectable way at the same time, which checks that both counters move by one each. The long sweeps push both counters past their limit, so a wrapping counter shows up.

// File: rtl/secded_tag_pkg.sv
package secded_tag_pkg;

    localparam int TAG_W = 31;
    localparam int CHK_W = 6;
    localparam int CW_W  = TAG_W + CHK_W + 1;

    typedef logic [TAG_W-1:0] tag_t;
    typedef logic [CW_W-1:0]  cw_t;

    typedef enum logic [1:0] {
        ECC_CLEAN = 2'd0,
        ECC_FIXED = 2'd1,
        ECC_FATAL = 2'd2
    } ecc_kind_e;

    typedef struct packed {
        ecc_kind_e kind;
        tag_t      tag;
        cw_t       fixed_cw;
    } ecc_result_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOK = 2'd1,
        ST_FIX  = 2'd2
    } ctl_state_e;

    function automatic logic is_pow2(int p);
        return (p & (p - 1)) == 0;
    endfunction

    // Position 0: overall parity; powers of two: check bits; rest: tag bits ascending.
    function automatic cw_t ecc_encode(tag_t t);
        cw_t  cw;
        int   d;
        logic x;
        cw = '0;
        d  = 0;
        for (int p = 1; p < CW_W; p++) begin
            if (!is_pow2(p)) begin
                cw[p] = t[d];
                d++;
            end
        end
        for (int c = 0; c < CHK_W; c++) begin
            x = 1'b0;
            for (int p = 1; p < CW_W; p++) begin
                if (((p >> c) & 1) == 1 && p != (1 << c)) x ^= cw[p];
            end
            cw[1 << c] = x;
        end
        cw[0] = ^cw[CW_W-1:1];
        return cw;
    endfunction

    function automatic ecc_result_t ecc_decode(cw_t cw);
        ecc_result_t      r;
        logic [CHK_W-1:0] syn;
        logic             par;
        int               d;
        syn = '0;
        for (int p = 1; p < CW_W; p++) begin
            if (cw[p]) syn ^= CHK_W'(p);
        end
        par        = ^cw;
        r.fixed_cw = cw;
        if (!par) begin
            r.kind = (syn == '0) ? ECC_CLEAN : ECC_FATAL;
        end else if (int'(syn) < CW_W) begin
            r.kind          = ECC_FIXED;
            r.fixed_cw[syn] = ~cw[syn];
        end else begin
            r.kind = ECC_FATAL;
        end
        d     = 0;
        r.tag = '0;
        for (int p = 1; p < CW_W; p++) begin
            if (!is_pow2(p)) begin
                r.tag[d] = r.fixed_cw[p];
                d++;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/tag_ecc_check.sv
module tag_ecc_check
    import secded_tag_pkg::*;
(
    input  logic        valid_i,
    input  cw_t         cw_i,
    output ecc_result_t res_o
);
    always_comb begin
        res_o = ecc_decode(cw_i);
        // An invalid way is never inspected or scrubbed.
        if (!valid_i) res_o.kind = ECC_CLEAN;
    end
endmodule

// File: rtl/tag_store.sv
module tag_store
    import secded_tag_pkg::*;
#(
    parameter  int SETS  = 4,
    parameter  int WAYS  = 2,
    localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] rd_set_i,
    output logic [WAYS-1:0]  rd_vld_o,
    output cw_t [WAYS-1:0]   rd_cw_o,
    input  logic             fill_en_i,
    input  logic [SET_W-1:0] fill_set_i,
    input  logic [WAY_W-1:0] fill_way_i,
    input  cw_t              fill_cw_i,
    input  logic             fix_en_i,
    input  logic [SET_W-1:0] fix_set_i,
    input  logic [WAYS-1:0]  fix_keep_i,
    input  logic [WAYS-1:0]  fix_kill_i,
    input  cw_t [WAYS-1:0]   fix_cw_i
);
    logic vld_arr [SETS][WAYS];
    cw_t  cw_arr  [SETS][WAYS];

    for (genvar s = 0; s < SETS; s++) begin : g_set
        for (genvar w = 0; w < WAYS; w++) begin : g_way
            logic vld_q;
            cw_t  cw_q;
            logic fix_touch;
            logic fill_hit;

            assign fix_touch = fix_en_i && (fix_set_i == SET_W'(s))
                               && (fix_keep_i[w] || fix_kill_i[w]);
            assign fill_hit  = fill_en_i && (fill_set_i == SET_W'(s))
                               && (fill_way_i == WAY_W'(w));

            // Scrub writes win over a fill to the same entry.
            always_ff @(posedge clk) begin
                if (rst) begin
                    vld_q <= 1'b0;
                end else if (fix_touch) begin
                    if (fix_kill_i[w]) vld_q <= 1'b0;
                end else if (fill_hit) begin
                    vld_q <= 1'b1;
                end
            end

            always_ff @(posedge clk) begin
                if (fix_touch) begin
                    if (fix_keep_i[w]) cw_q <= fix_cw_i[w];
                end else if (fill_hit) begin
                    cw_q <= fill_cw_i;
                end
            end

            assign vld_arr[s][w] = vld_q;
            assign cw_arr[s][w]  = cw_q;
        end
    end

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            rd_vld_o[w] = vld_arr[rd_set_i][w];
            rd_cw_o[w]  = cw_arr[rd_set_i][w];
        end
    end
endmodule

// File: rtl/tag_err_stats.sv
module tag_err_stats #(
    parameter  int CNT_W = 8,
    parameter  int WAYS  = 2,
    localparam int N_W   = $clog2(WAYS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ev_en_i,
    input  logic [N_W-1:0]   ce_n_i,
    input  logic [N_W-1:0]   ue_n_i,
    output logic             ce_flag_o,
    output logic             ue_flag_o,
    output logic [CNT_W-1:0] ce_cnt_o,
    output logic [CNT_W-1:0] ue_cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W:0] ce_sum;
    logic [CNT_W:0] ue_sum;

    assign ce_sum = {1'b0, ce_cnt_o} + (CNT_W+1)'(ce_n_i);
    assign ue_sum = {1'b0, ue_cnt_o} + (CNT_W+1)'(ue_n_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            ce_flag_o <= 1'b0;
            ue_flag_o <= 1'b0;
            ce_cnt_o  <= '0;
            ue_cnt_o  <= '0;
        end else if (ev_en_i) begin
            if (ce_n_i != '0) ce_flag_o <= 1'b1;
            if (ue_n_i != '0) ue_flag_o <= 1'b1;
            ce_cnt_o <= ce_sum[CNT_W] ? CNT_MAX : ce_sum[CNT_W-1:0];
            ue_cnt_o <= ue_sum[CNT_W] ? CNT_MAX : ue_sum[CNT_W-1:0];
        end
    end

    assert_ce_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        ce_flag_o |=> ce_flag_o);
    assert_ue_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        ue_flag_o |=> ue_flag_o);
    assert_ce_hold_max_R8: assert property (@(posedge clk) disable iff (rst)
        (ce_cnt_o == CNT_MAX) |=> (ce_cnt_o == CNT_MAX));
    assert_ue_no_decrease_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (ue_cnt_o >= $past(ue_cnt_o)));
endmodule

// File: rtl/secded_tag_check.sv
module secded_tag_check
    import secded_tag_pkg::*;
#(
    parameter  int SETS  = 4,
    parameter  int WAYS  = 2,
    parameter  int CNT_W = 8,
    localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int N_W   = $clog2(WAYS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid_i,
    output logic             req_ready_o,
    input  logic [SET_W-1:0] req_set_i,
    input  logic [TAG_W-1:0] req_tag_i,
    output logic             rsp_valid_o,
    output logic             rsp_hit_o,
    output logic [WAY_W-1:0] rsp_way_o,
    input  logic             fill_valid_i,
    input  logic [SET_W-1:0] fill_set_i,
    input  logic [WAY_W-1:0] fill_way_i,
    input  logic [TAG_W-1:0] fill_tag_i,
    input  logic [CW_W-1:0]  fill_flip_i,
    output logic             err_ce_o,
    output logic             err_ue_o,
    output logic [CNT_W-1:0] ce_count_o,
    output logic [CNT_W-1:0] ue_count_o
);
    ctl_state_e       state_q;
    logic [SET_W-1:0] set_q;
    tag_t             tag_q;

    logic [WAYS-1:0]  rd_vld;
    cw_t [WAYS-1:0]   rd_cw;
    ecc_result_t      res [WAYS];
    cw_t [WAYS-1:0]   fix_cw;
    logic [WAYS-1:0]  keep_vec;
    logic [WAYS-1:0]  kill_vec;
    logic [WAYS-1:0]  hit_vec;
    logic [WAY_W-1:0] hit_way;
    logic [N_W-1:0]   ce_n;
    logic [N_W-1:0]   ue_n;
    logic             any_err;
    cw_t              fill_cw;

    assign fill_cw = ecc_encode(fill_tag_i) ^ fill_flip_i;

    tag_store #(.SETS(SETS), .WAYS(WAYS)) store_i (
        .clk        (clk),
        .rst        (rst),
        .rd_set_i   (set_q),
        .rd_vld_o   (rd_vld),
        .rd_cw_o    (rd_cw),
        .fill_en_i  (fill_valid_i),
        .fill_set_i (fill_set_i),
        .fill_way_i (fill_way_i),
        .fill_cw_i  (fill_cw),
        .fix_en_i   (state_q == ST_FIX),
        .fix_set_i  (set_q),
        .fix_keep_i (keep_vec),
        .fix_kill_i (kill_vec),
        .fix_cw_i   (fix_cw)
    );

    for (genvar w = 0; w < WAYS; w++) begin : g_dec
        tag_ecc_check dec_i (
            .valid_i (rd_vld[w]),
            .cw_i    (rd_cw[w]),
            .res_o   (res[w])
        );
        assign fix_cw[w]   = res[w].fixed_cw;
        assign keep_vec[w] = (res[w].kind == ECC_FIXED);
        assign kill_vec[w] = (res[w].kind == ECC_FATAL);
        assign hit_vec[w]  = rd_vld[w] && (res[w].kind == ECC_CLEAN)
                             && (res[w].tag == tag_q);
    end

    always_comb begin
        ce_n    = '0;
        ue_n    = '0;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (keep_vec[w]) ce_n = ce_n + N_W'(1);
            if (kill_vec[w]) ue_n = ue_n + N_W'(1);
        end
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end

    assign any_err     = (keep_vec | kill_vec) != '0;
    assign req_ready_o = (state_q == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            set_q       <= '0;
            tag_q       <= '0;
            rsp_valid_o <= 1'b0;
            rsp_hit_o   <= 1'b0;
            rsp_way_o   <= '0;
        end else begin
            rsp_valid_o <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid_i) begin
                        set_q   <= req_set_i;
                        tag_q   <= req_tag_i;
                        state_q <= ST_LOOK;
                    end
                end
                ST_LOOK: begin
                    if (any_err) begin
                        state_q <= ST_FIX;
                    end else begin
                        rsp_valid_o <= 1'b1;
                        rsp_hit_o   <= hit_vec != '0;
                        rsp_way_o   <= hit_way;
                        state_q     <= ST_IDLE;
                    end
                end
                ST_FIX:  state_q <= ST_LOOK;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    tag_err_stats #(.CNT_W(CNT_W), .WAYS(WAYS)) stats_i (
        .clk       (clk),
        .rst       (rst),
        .ev_en_i   ((state_q == ST_LOOK) && any_err),
        .ce_n_i    (ce_n),
        .ue_n_i    (ue_n),
        .ce_flag_o (err_ce_o),
        .ue_flag_o (err_ue_o),
        .ce_cnt_o  (ce_count_o),
        .ue_cnt_o  (ue_count_o)
    );

    assert_rsp_single_R1: assert property (@(posedge clk) disable iff (rst)
        rsp_valid_o |=> !rsp_valid_o);
    assert_rsp_when_free_R3: assert property (@(posedge clk) disable iff (rst)
        rsp_valid_o |-> req_ready_o);
    assert_retry_clean_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FIX && !fill_valid_i) |=> !any_err);
    assert_killed_never_hits_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FIX && !fill_valid_i) |=> ((hit_vec & $past(kill_vec)) == '0));
endmodule

// File: tb/secded_tag_check_tb_top.sv
module secded_tag_check_tb_top;
    localparam int SETS  = 4;
    localparam int WAYS  = 2;
    localparam int CNT_W = 8;
    localparam int TW    = 31;
    localparam int CWW   = 38;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid_i = 1'b0;
    logic req_ready_o;
    logic [1:0] req_set_i = '0;
    logic [TW-1:0] req_tag_i = '0;
    logic rsp_valid_o, rsp_hit_o;
    logic [0:0] rsp_way_o;
    logic fill_valid_i = 1'b0;
    logic [1:0] fill_set_i = '0;
    logic [0:0] fill_way_i = '0;
    logic [TW-1:0] fill_tag_i = '0;
    logic [CWW-1:0] fill_flip_i = '0;
    logic err_ce_o, err_ue_o;
    logic [CNT_W-1:0] ce_count_o, ue_count_o;

    int checks = 0;
    int fails  = 0;
    int ce_m   = 0;
    int ue_m   = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    secded_tag_check #(.SETS(SETS), .WAYS(WAYS), .CNT_W(CNT_W)) dut_i (.*);

    function automatic logic [TW-1:0] tag_of(int s, int w);
        return TW'((s * WAYS + w + 1) * 32'h0B5A_3C1D);
    endfunction

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    task automatic fill(input int s, input int w, input logic [TW-1:0] t, input logic [CWW-1:0] flip);
        @(negedge clk);
        fill_valid_i = 1'b1;
        fill_set_i   = 2'(s);
        fill_way_i   = 1'(w);
        fill_tag_i   = t;
        fill_flip_i  = flip;
        @(negedge clk);
        fill_valid_i = 1'b0;
        fill_flip_i  = '0;
    endtask

    task automatic lookup(input int s, input logic [TW-1:0] t, input bit exp_hit,
                          input int exp_way, input int exp_lat, input string rq);
        int  lat;
        bit  busy_ok;
        @(negedge clk);
        chk(req_ready_o == 1'b1, {rq, " ready before request"}, req_ready_o, 1);
        req_valid_i = 1'b1;
        req_set_i   = 2'(s);
        req_tag_i   = t;
        @(negedge clk);
        req_valid_i = 1'b0;
        lat     = 1;
        busy_ok = 1'b1;
        while (!rsp_valid_o && lat < 12) begin
            if (req_ready_o) busy_ok = 1'b0;
            @(negedge clk);
            lat++;
        end
        chk(lat == exp_lat, {rq, " latency"}, lat, exp_lat);
        chk(busy_ok, "R3 ready low while busy", busy_ok, 1);
        chk(rsp_hit_o == exp_hit, {rq, " hit"}, rsp_hit_o, exp_hit);
        if (exp_hit) chk(rsp_way_o == 1'(exp_way), {rq, " way"}, rsp_way_o, exp_way);
    endtask

    task automatic chk_stats(input string rq);
        chk(ce_count_o == CNT_W'(ce_m), {rq, " ce count"}, ce_count_o, ce_m);
        chk(ue_count_o == CNT_W'(ue_m), {rq, " ue count"}, ue_count_o, ue_m);
        chk(err_ce_o == (ce_m != 0), {rq, " ce flag"}, err_ce_o, ce_m != 0);
        chk(err_ue_o == (ue_m != 0), {rq, " ue flag"}, err_ue_o, ue_m != 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R9: reset state
        chk(req_ready_o == 1'b1, "R9 ready", req_ready_o, 1);
        chk(rsp_valid_o == 1'b0, "R9 rsp_valid", rsp_valid_o, 0);
        chk_stats("R9");
        for (int s = 0; s < SETS; s++) lookup(s, tag_of(s, 0), 0, 0, 2, "R9 empty set");

        // R10 / R1: clean fills and hits
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) fill(s, w, tag_of(s, w), '0);
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) lookup(s, tag_of(s, w), 1, w, 2, "R1 R10 clean hit");
        // R2: absent tag misses
        lookup(3, tag_of(0, 0), 0, 0, 2, "R2 absent tag");
        lookup(1, 31'h7FFF_FFFF, 0, 0, 2, "R2 all-ones tag");
        chk_stats("R2 no events");

        // R7: single correctable event, uncorrectable flag stays low
        fill(0, 0, tag_of(0, 0), 38'(1) << 7);
        lookup(0, tag_of(0, 0), 1, 0, 4, "R7 single event");
        ce_m++;
        chk_stats("R7 ce only");
        // R7: mixed set, one repaired way and one invalidated way
        fill(2, 0, tag_of(2, 0), 38'(1) << 5);
        fill(2, 1, tag_of(2, 1), (38'(1) << 3) | (38'(1) << 9));
        lookup(2, tag_of(2, 0), 1, 0, 4, "R7 mixed set");
        ce_m++;
        ue_m++;
        chk_stats("R7 mixed");
        lookup(2, tag_of(2, 1), 0, 0, 2, "R6 killed way misses");
        fill(2, 1, tag_of(2, 1), '0);

        // R3 R4 R11: every single-bit flip in every entry
        for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
                for (int b = 0; b < CWW; b++) begin
                    fill(s, w, tag_of(s, w), 38'(1) << b);
                    if (b % 2 == 1) begin
                        lookup(s, tag_of(s, 1 - w), 1, 1 - w, 4, "R3 flip, other way");
                    end else if (b == 0) begin
                        lookup(s, tag_of(s, w), 1, w, 4, "R11 parity bit flip");
                    end else begin
                        lookup(s, tag_of(s, w), 1, w, 4, "R3 flip, own way");
                    end
                    if (ce_m < CMAX) ce_m++;
                    chk_stats("R7 R8 single sweep");
                    lookup(s, tag_of(s, w), 1, w, 2, "R4 after scrub");
                end
            end
        end
        chk(ce_count_o == CNT_W'(CMAX), "R8 ce saturated", ce_count_o, CMAX);

        // R5 R6: every double-bit flip in set 1 way 0, clean neighbour in way 1
        for (int i = 0; i < CWW; i++) begin
            for (int j = i + 1; j < CWW; j++) begin
                fill(1, 0, tag_of(1, 0), (38'(1) << i) | (38'(1) << j));
                lookup(1, tag_of(1, 0), 0, 0, 4, "R5 double flip miss");
                if (ue_m < CMAX) ue_m++;
                lookup(1, tag_of(1, 1), 1, 1, 2, "R5 neighbour intact");
                lookup(1, tag_of(1, 0), 0, 0, 2, "R6 stays missing");
                chk_stats("R6 R8 double sweep");
            end
        end
        chk(ue_count_o == CNT_W'(CMAX), "R8 ue saturated", ue_count_o, CMAX);

        done = 1'b1;
        summary();
    end
endmodule